// File: doc/BRIEF.md
# Header-Routed Stream Switch Port

This block makes the route decision for one input of a node's switch. A token stream opens with a header that names a destination node. The block collects the header bytes and compares the destination with the node's programmable switch identifier. If every compared bit matches, the stream is delivered to a local tile, which is chosen by the core and channel fields of the header. If any bit differs, the stream is sent to an outbound link. That link's direction comes from a routing table, indexed by the most significant bit position in which the two identifiers differ.

Once a route is chosen, the block holds it like a circuit. Every later token passes straight through to the output with its valid and ready handshake, and the route fields stay fixed. An END or PAUSE control token is forwarded on the held route, and then the route is released. The next token is taken as a new header.

A configuration register selects between a short 1-byte header and a full 3-byte header. When there are several cores per switch, the lowest address bits select the core and are left out of the node comparison.

Top module: `sw_route_port`

## Requirements
- R1: After reset the block is in 3-byte header mode, no route is held (`route_active`=0), `out_valid` is 0 and `in_ready` is 1. Reset also returns the switch identifier and every routing-table entry to 0. A reset that arrives while 1-byte mode is selected restores 3-byte mode.
- R2: In 3-byte mode the header is three bytes. The high byte of the 16-bit destination comes first, then the low byte, then a channel byte. `in_ready` is 1 while a header is being collected. `route_active` rises on the clock edge that accepts the third byte.
- R3: Writing 1 to bit 0 of config address 0x04 selects 1-byte mode. In that mode the single header byte carries a 3-bit node identifier in bits [7:5], compared with switch-identifier bits [2:0], and a channel in bits [4:0]. The reported core is 0.
- R4: When the compared bits all match, `route_local` is 1. `route_core` equals the low CORE_BITS bits of the destination (default 2) and `route_chan` equals the channel field.
- R5: When any compared bit differs, `route_local` is 0 and `route_dir` equals the routing-table entry at the highest differing bit position. In 3-byte mode the low CORE_BITS destination bits are excluded from the compare.
- R6: The switch identifier is written at config address 0x05 (16 bits). Routing-table entry i (2 bits, data bits [1:0]) is written at address 0x10+i, for i from 0 to 15. Writes to any other address change no routing result.
- R7: While a route is held, `out_valid`=`in_valid`, `out_data`=`in_data`, `out_ctrl`=`in_ctrl` and `in_ready`=`out_ready`. The route fields stay stable.
- R8: A control token (`in_ctrl`=1) with code 0x01 (END) or 0x02 (PAUSE) is forwarded and then releases the route on the edge that accepts it. Other control codes, data tokens carrying 0x01, and tokens not accepted do not release it.
- R9: While a header is being collected, `out_valid` stays 0, so header bytes are never emitted as tokens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 8 | Config register address |
| cfg_wdata | input | 16 | Config write data |
| in_valid | input | 1 | Incoming token valid |
| in_ctrl | input | 1 | Incoming token is a control token |
| in_data | input | 8 | Incoming token byte |
| in_ready | output | 1 | Block accepts the incoming token |
| out_valid | output | 1 | Outgoing token valid on the held route |
| out_ctrl | output | 1 | Outgoing token is a control token |
| out_data | output | 8 | Outgoing token byte |
| out_ready | input | 1 | Downstream accepts the outgoing token |
| route_active | output | 1 | A route is held |
| route_local | output | 1 | Held route delivers to a local tile |
| route_dir | output | 2 | Outbound link direction for a non-local route |
| route_core | output | 8 | Local core number (zero-extended) |
| route_chan | output | 8 | Destination channel |

## Verification
The bench covers several kinds of mismatch. Some differ only in the core bits; a design that compared those bits would send local traffic off-node. Others differ in both high and low bit positions; a design that indexed the table by the lowest differing bit would report the wrong direction. The bench also checks that a reset issued in 1-byte mode returns to three-byte parsing; a design that did not would open a route after the first byte. It checks as well that only accepted control tokens carrying END or PAUSE release a route; a looser release test would drop a held route on a data byte or on a stalled token.

// File: rtl/sw_route_pkg.sv
package sw_route_pkg;

    typedef enum logic {
        ST_HDR   = 1'b0,
        ST_ROUTE = 1'b1
    } route_st_e;

    localparam logic [7:0] TOK_END   = 8'h01;
    localparam logic [7:0] TOK_PAUSE = 8'h02;

    localparam logic [7:0] ADDR_MODE  = 8'h04;
    localparam logic [7:0] ADDR_ID    = 8'h05;
    localparam logic [7:0] ADDR_TABLE = 8'h10;

endpackage

// File: rtl/sw_cfg_regs.sv
module sw_cfg_regs #(
    parameter int ID_W   = 16,
    parameter int DIR_W  = 2,
    parameter int ADDR_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [ADDR_W-1:0]         cfg_addr,
    input  logic [ID_W-1:0]           cfg_wdata,
    output logic                      short_mode,
    output logic [ID_W-1:0]           sw_id,
    output logic [ID_W*DIR_W-1:0]     rt_tbl
);
    import sw_route_pkg::*;

    typedef struct packed {
        logic                       mode;
        logic [ID_W-1:0]            id;
        logic [ID_W-1:0][DIR_W-1:0] tbl;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            if (cfg_addr == ADDR_W'(ADDR_MODE)) begin
                cfg_d.mode = cfg_wdata[0];
            end
            if (cfg_addr == ADDR_W'(ADDR_ID)) begin
                cfg_d.id = cfg_wdata;
            end
            for (int i = 0; i < ID_W; i++) begin
                if (cfg_addr == ADDR_W'(int'(ADDR_TABLE) + i)) begin
                    cfg_d.tbl[i] = cfg_wdata[DIR_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign short_mode = cfg_q.mode;
    assign sw_id      = cfg_q.id;
    assign rt_tbl     = cfg_q.tbl;

endmodule

// File: rtl/sw_route_calc.sv
module sw_route_calc #(
    parameter int ID_W      = 16,
    parameter int CORE_BITS = 2,
    parameter int DIR_W     = 2,
    parameter int SHORT_W   = 3
) (
    input  logic                  short_mode,
    input  logic [7:0]            hdr_hi,
    input  logic [7:0]            hdr_lo,
    input  logic [7:0]            hdr_last,
    input  logic [ID_W-1:0]       sw_id,
    input  logic [ID_W*DIR_W-1:0] rt_tbl,
    output logic                  is_local,
    output logic [DIR_W-1:0]      dir,
    output logic [7:0]            core,
    output logic [7:0]            chan
);
    localparam int POS_W   = $clog2(ID_W);
    localparam int CHAN_SW = 8 - SHORT_W;
    localparam logic [ID_W-1:0] CORE_MASK = ID_W'((1 << CORE_BITS) - 1);

    logic [ID_W-1:0]  dest;
    logic [ID_W-1:0]  diff_long;
    logic [ID_W-1:0]  diff_short;
    logic [ID_W-1:0]  diff;
    logic [POS_W-1:0] top_pos;

    function automatic logic [POS_W-1:0] top_bit(input logic [ID_W-1:0] v);
        logic [POS_W-1:0] p;
        p = '0;
        for (int i = 0; i < ID_W; i++) begin
            if (v[i]) p = POS_W'(i);
        end
        return p;
    endfunction

    always_comb begin
        dest       = ID_W'({hdr_hi, hdr_lo});
        diff_long  = (dest ^ sw_id) & ~CORE_MASK;
        diff_short = ID_W'(hdr_last[7 -: SHORT_W] ^ sw_id[SHORT_W-1:0]);
        diff       = short_mode ? diff_short : diff_long;
        is_local   = (diff == '0);
        top_pos    = top_bit(diff);
        dir        = rt_tbl[top_pos*DIR_W +: DIR_W];
        core       = short_mode ? 8'h00 : 8'(dest & CORE_MASK);
        chan       = short_mode ? 8'(hdr_last[CHAN_SW-1:0]) : hdr_last;
    end

endmodule

// File: rtl/sw_route_port.sv
module sw_route_port #(
    parameter int ID_W      = 16,
    parameter int CORE_BITS = 2,
    parameter int DIR_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_addr,
    input  logic [15:0]      cfg_wdata,
    input  logic             in_valid,
    input  logic             in_ctrl,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic             out_ctrl,
    output logic [7:0]       out_data,
    input  logic             out_ready,
    output logic             route_active,
    output logic             route_local,
    output logic [DIR_W-1:0] route_dir,
    output logic [7:0]       route_core,
    output logic [7:0]       route_chan
);
    import sw_route_pkg::*;

    localparam int LONG_BYTES = 3;
    localparam int CNT_W      = $clog2(LONG_BYTES);

    typedef struct packed {
        route_st_e        st;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       b_hi;
        logic [7:0]       b_lo;
        logic             loc;
        logic [DIR_W-1:0] dir;
        logic [7:0]       core;
        logic [7:0]       chan;
    } port_t;

    port_t s_d, s_q;

    logic                  short_mode;
    logic [ID_W-1:0]       sw_id;
    logic [ID_W*DIR_W-1:0] rt_tbl;
    logic                  c_local;
    logic [DIR_W-1:0]      c_dir;
    logic [7:0]            c_core;
    logic [7:0]            c_chan;
    logic                  hdr_last;
    logic                  is_release;

    sw_cfg_regs #(
        .ID_W   (ID_W),
        .DIR_W  (DIR_W),
        .ADDR_W (8)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (ID_W'(cfg_wdata)),
        .short_mode (short_mode),
        .sw_id      (sw_id),
        .rt_tbl     (rt_tbl)
    );

    sw_route_calc #(
        .ID_W      (ID_W),
        .CORE_BITS (CORE_BITS),
        .DIR_W     (DIR_W),
        .SHORT_W   (3)
    ) u_calc (
        .short_mode (short_mode),
        .hdr_hi     (s_q.b_hi),
        .hdr_lo     (s_q.b_lo),
        .hdr_last   (in_data),
        .sw_id      (sw_id),
        .rt_tbl     (rt_tbl),
        .is_local   (c_local),
        .dir        (c_dir),
        .core       (c_core),
        .chan       (c_chan)
    );

    always_comb begin
        s_d        = s_q;
        hdr_last   = short_mode || (s_q.cnt == CNT_W'(LONG_BYTES - 1));
        is_release = in_ctrl && ((in_data == TOK_END) || (in_data == TOK_PAUSE));
        if (s_q.st == ST_HDR) begin
            if (in_valid) begin
                if (hdr_last) begin
                    s_d.st   = ST_ROUTE;
                    s_d.cnt  = '0;
                    s_d.loc  = c_local;
                    s_d.dir  = c_dir;
                    s_d.core = c_core;
                    s_d.chan = c_chan;
                end else begin
                    if (s_q.cnt == '0) begin
                        s_d.b_hi = in_data;
                    end else begin
                        s_d.b_lo = in_data;
                    end
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end else begin
            if (in_valid && out_ready && is_release) begin
                s_d.st = ST_HDR;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_HDR, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign route_active = (s_q.st == ST_ROUTE);
    assign in_ready     = route_active ? out_ready : 1'b1;
    assign out_valid    = route_active && in_valid;
    assign out_ctrl     = in_ctrl;
    assign out_data     = in_data;
    assign route_local  = s_q.loc;
    assign route_dir    = s_q.dir;
    assign route_core   = s_q.core;
    assign route_chan   = s_q.chan;

endmodule

// File: rtl/sw_route_port_chk.sv
module sw_route_port_chk #(
    parameter int DIR_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ctrl,
    input logic [7:0]       in_data,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             route_active,
    input logic             route_local,
    input logic [DIR_W-1:0] route_dir,
    input logic [7:0]       route_chan
);
    logic rel_tok;
    assign rel_tok = in_valid && in_ready && in_ctrl &&
                     ((in_data == 8'h01) || (in_data == 8'h02));

    // R9: header bytes never leave the block
    p_hdr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !route_active |-> !out_valid);

    // R2: header bytes are always accepted
    p_hdr_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !route_active |-> in_ready);

    // R2: a route only opens after an accepted byte
    p_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!route_active && !in_valid) |=> !route_active);

    // R7: backpressure is passed straight through
    p_backpressure_r7: assert property (@(posedge clk) disable iff (!rst_n)
        route_active |-> (in_ready == out_ready));

    // R7: held route stays fixed until released
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (route_active && !rel_tok) |=> (route_active && $stable(route_local)
                                        && $stable(route_dir) && $stable(route_chan)));

    // R8: accepted END or PAUSE frees the route
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (route_active && rel_tok) |=> !route_active);

endmodule

bind sw_route_port sw_route_port_chk #(.DIR_W(DIR_W)) u_chk (.*);

// File: tb/sw_route_port_test.sv
`timescale 1ns/100ps
module sw_route_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_ctrl = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic        out_ctrl;
    logic [7:0]  out_data;
    logic        out_ready = 1'b1;
    logic        route_active;
    logic        route_local;
    logic [1:0]  route_dir;
    logic [7:0]  route_core;
    logic [7:0]  route_chan;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sw_route_port uut (.*);

    typedef struct packed {
        logic       mode;
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] b2;
        logic       loc;
        logic [1:0] dir;
        logic [7:0] core;
        logic [7:0] chan;
    } vec_t;

    // switch id A5C4, table entry i = i mod 4
    localparam vec_t VECS [11] = '{
        '{1'b0, 8'hA5, 8'hC4, 8'h33, 1'b1, 2'd0, 8'h00, 8'h33},
        '{1'b0, 8'hA5, 8'hC7, 8'h07, 1'b1, 2'd0, 8'h03, 8'h07},
        '{1'b0, 8'h25, 8'hC4, 8'h10, 1'b0, 2'd3, 8'h00, 8'h10},
        '{1'b0, 8'hA5, 8'hC0, 8'h11, 1'b0, 2'd2, 8'h00, 8'h11},
        '{1'b0, 8'hA5, 8'hCC, 8'h12, 1'b0, 2'd3, 8'h00, 8'h12},
        '{1'b0, 8'hA4, 8'hC4, 8'h13, 1'b0, 2'd0, 8'h00, 8'h13},
        '{1'b0, 8'hA7, 8'hC4, 8'h14, 1'b0, 2'd1, 8'h00, 8'h14},
        '{1'b1, 8'h8A, 8'h00, 8'h00, 1'b1, 2'd0, 8'h00, 8'h0A},
        '{1'b1, 8'h01, 8'h00, 8'h00, 1'b0, 2'd2, 8'h00, 8'h01},
        '{1'b1, 8'hBF, 8'h00, 8'h00, 1'b0, 2'd0, 8'h00, 8'h1F},
        '{1'b1, 8'h60, 8'h00, 8'h00, 1'b0, 2'd2, 8'h00, 8'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // drive one token; checks run between drive and the accepting edge
    task automatic drive(input logic c, input logic [7:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_ctrl = c; in_data = d;
        #1;
    endtask

    task automatic finish_tok();
        @(posedge clk);
        #1;
        in_valid = 1'b0; in_ctrl = 1'b0;
    endtask

    task automatic hdr_byte(input logic [7:0] d);
        drive(1'b0, d);
        chk("R9 header byte not emitted", 32'(out_valid), 32'd0);
        finish_tok();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 route_active", 32'(route_active), 32'd0);
        chk("R1 out_valid", 32'(out_valid), 32'd0);
        chk("R1 in_ready", 32'(in_ready), 32'd1);
        @(negedge clk);
        rst_n = 1'b1;

        cfg_write(8'h05, 16'hA5C4);
        for (int i = 0; i < 16; i++) cfg_write(8'(8'h10 + i), 16'(i % 4));

        foreach (VECS[k]) begin
            string tag;
            tag = VECS[k].mode ? "R3" : (VECS[k].loc ? "R4" : "R5");
            cfg_write(8'h04, {15'd0, VECS[k].mode});
            hdr_byte(VECS[k].b0);
            if (!VECS[k].mode) begin
                chk("R2 no route after byte 1", 32'(route_active), 32'd0);
                hdr_byte(VECS[k].b1);
                chk("R2 no route after byte 2", 32'(route_active), 32'd0);
                hdr_byte(VECS[k].b2);
            end
            chk("R2 route opened", 32'(route_active), 32'd1);
            chk({tag, " local"}, 32'(route_local), 32'(VECS[k].loc));
            if (!VECS[k].loc) chk({tag, " dir"}, 32'(route_dir), 32'(VECS[k].dir));
            chk({tag, " core"}, 32'(route_core), 32'(VECS[k].core));
            chk({tag, " chan"}, 32'(route_chan), 32'(VECS[k].chan));
            drive(1'b0, 8'h5A);
            chk("R7 pass valid", 32'(out_valid), 32'd1);
            chk("R7 pass data", 32'({out_ctrl, out_data}), 32'h05A);
            finish_tok();
            drive(1'b1, (k % 2) ? 8'h02 : 8'h01);
            chk("R8 release token forwarded", 32'({out_valid, out_ctrl}), 32'h3);
            finish_tok();
            chk("R8 route released", 32'(route_active), 32'd0);
        end

        // R6: writes to unmapped addresses leave routing unchanged
        cfg_write(8'h04, 16'h0000);
        cfg_write(8'h06, 16'h0000);
        cfg_write(8'h20, 16'h0002);
        cfg_write(8'h1F, 16'h0002);
        hdr_byte(8'hA5); hdr_byte(8'hC4); hdr_byte(8'h01);
        chk("R6 stray write ignored", 32'(route_local), 32'd1);
        drive(1'b1, 8'h01); finish_tok();
        hdr_byte(8'h25); hdr_byte(8'hC4); hdr_byte(8'h01);
        chk("R6 table entry 15 rewritten", 32'(route_dir), 32'd2);

        // R8: other tokens do not release
        drive(1'b1, 8'h05); finish_tok();
        chk("R8 other ctrl keeps route", 32'(route_active), 32'd1);
        drive(1'b0, 8'h01); finish_tok();
        chk("R8 data 0x01 keeps route", 32'(route_active), 32'd1);

        // R7/R8: stalled END is not accepted
        out_ready = 1'b0;
        drive(1'b1, 8'h01);
        chk("R7 backpressure", 32'(in_ready), 32'd0);
        finish_tok();
        chk("R8 stalled END keeps route", 32'(route_active), 32'd1);
        chk("R7 route fields stable", 32'(route_dir), 32'd2);
        out_ready = 1'b1;
        drive(1'b1, 8'h02); finish_tok();
        chk("R8 PAUSE releases", 32'(route_active), 32'd0);

        // R1: reset restores 3-byte mode and clears tables
        cfg_write(8'h04, 16'h0001);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        hdr_byte(8'h8A);
        chk("R1 3-byte mode after reset", 32'(route_active), 32'd0);
        hdr_byte(8'hC4); hdr_byte(8'h11);
        chk("R1 route after three bytes", 32'(route_active), 32'd1);
        chk("R1 cleared id gives mismatch", 32'({route_local, route_dir}), 32'd0);
        drive(1'b1, 8'h01); finish_tok();

        repeat (2) @(posedge clk);
        summary();
    end

endmodule